// File: doc/BRIEF.md
# IOMMU Page Translation Lookup Unit

This unit sits between a DMA-capable device and system memory. It turns a device bus address into a system physical address by looking up a single-level table of translation entries. The table is held in on-chip registers. Each entry holds a physical page base in its upper bits and a two-bit access code in its lowest two bits. The page size is set at run time by a shift amount. A bus window offset places the table's range anywhere in the bus address space.

Software, or an external updater, first loads entries through a simple indexed write port. It then opens the window with an enable pulse that carries the shift, the offset and the entry count. After that, device requests are sent with a valid/ready handshake. Each accepted request is answered one cycle later with the following fields:

- the physical address;
- the page-aligned window-relative address;
- the page-offset mask;
- the access code of the entry;
- a fault flag.

The fault flag is raised when the request lies outside the window, or when the request type is not allowed by the entry.

Top module: `iommu_xlate_unit`

## Requirements
- R1: After reset the window holds entry count 0, page shift 12 and offset 0, and every table entry is zero. No response is pending, and every lookup faults until the window is enabled and entries are written.
- R2: The access code is bits [1:0] of the entry: 0 = none, 1 = read only, 2 = write only, 3 = read and write. It is returned on `rsp_perm` for every in-window lookup.
- R3: `rsp_fault` is 1 for an in-window lookup when the access code is 0, when a read (`req_write`=0) hits code 2, or when a write (`req_write`=1) hits code 1. It is 0 otherwise.
- R4: The entry index is (`req_addr` - offset) >> shift. When `req_addr` is below the offset, or the index is at least the entry count, the response has perm 0, fault 1, address 0, IOVA 0 and a mask of all ones.
- R5: For an in-window lookup, mask = 2^shift - 1. `rsp_pa` is the entry with its low shift bits cleared, ORed with the low shift bits of the window-relative address. `rsp_iova` is the window-relative address with its low shift bits cleared.
- R6: An enable pulse loads shift, offset and count only while the stored count is 0; otherwise it is ignored. A requested count above the table depth is stored as the depth.
- R7: A disable pulse sets count, shift and offset to 0 and clears every table entry. It wins over an enable or a table write in the same cycle.
- R8: `req_ready` equals (not `rsp_valid`) or `rsp_ready`. A request accepted at one clock edge makes `rsp_valid` 1 after that edge. While `rsp_ready` is 0 the response holds every field unchanged.
- R9: A table write at index i stores the data in entry i. Every lookup accepted on a later edge sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Pulse: open the window with the values below |
| cfg_disable | input | 1 | Pulse: close the window and clear the table |
| cfg_shift | input | SHIFT_W | Page shift for enable |
| cfg_offset | input | ADDR_W | Bus window offset for enable |
| cfg_count | input | ADDR_W | Entry count for enable |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_idx | input | IDX_W | Table write index |
| tbl_wr_data | input | ENTRY_W | Table write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | ADDR_W | Device bus address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed when high with valid |
| rsp_pa | output | ENTRY_W | Translated physical address |
| rsp_iova | output | ADDR_W | Page-aligned window-relative address |
| rsp_mask | output | ENTRY_W | Page-offset mask, all ones on out-of-window |
| rsp_perm | output | 2 | Access code of the entry |
| rsp_fault | output | 1 | Access refused or out of window |

## Verification
A stale or corrupted window register shows up on the next accepted request, one cycle after it enters. It appears as a wrong page boundary in the mask and IOVA, or as a wrong in-window/out-of-window decision at the edges of the window. A bad table entry shows only when its own index is looked up, so the bench sweeps every index and the addresses on both sides of each window edge. The sweep covers three shift values with both read and write requests. A failure to clear entries on disable appears as a non-fault response after re-enabling without writes. A broken stall path appears as a response that changes while `rsp_ready` is low.

// File: rtl/iommu_xlate_pkg.sv
package iommu_xlate_pkg;

   // access code in the two low bits of every entry; bit0 grants read, bit1 grants write
   typedef enum logic [1:0] {
      PERM_NONE = 2'd0,
      PERM_RD   = 2'd1,
      PERM_WR   = 2'd2,
      PERM_RW   = 2'd3
   } perm_e;

   function automatic logic perm_blocks(input perm_e p, input logic is_write);
      return is_write ? ~p[1] : ~p[0];
   endfunction

endpackage

// File: rtl/iommu_win_cfg.sv
module iommu_win_cfg #(
   parameter int ADDR_W    = 32,
   parameter int DEPTH     = 64,
   parameter int SHIFT_W   = 5,
   parameter int CNT_W     = 7,
   parameter int DEF_SHIFT = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_i,
   input  logic               dis_i,
   input  logic [SHIFT_W-1:0] shift_i,
   input  logic [ADDR_W-1:0]  offset_i,
   input  logic [ADDR_W-1:0]  count_i,
   output logic [SHIFT_W-1:0] shift_o,
   output logic [ADDR_W-1:0]  offset_o,
   output logic [CNT_W-1:0]   count_o
);
   localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(DEPTH);

   logic [CNT_W-1:0] count_sat;
   assign count_sat = (count_i > DEPTH_A) ? CNT_W'(DEPTH) : count_i[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_o  <= SHIFT_W'(DEF_SHIFT);
         offset_o <= '0;
         count_o  <= '0;
      end else if (dis_i) begin
         shift_o  <= '0;
         offset_o <= '0;
         count_o  <= '0;
      end else if (en_i && (count_o == '0)) begin
         shift_o  <= shift_i;
         offset_o <= offset_i;
         count_o  <= count_sat;
      end
   end

   // R7
   win_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dis_i |=> (count_o == '0) && (shift_o == '0) && (offset_o == '0));
   // R6
   reenable_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_i && !dis_i && (count_o != '0) |=> $stable(count_o) && $stable(shift_o) && $stable(offset_o));
   // R6
   count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count_o <= CNT_W'(DEPTH));
endmodule

// File: rtl/iommu_entry_table.sv
module iommu_entry_table #(
   parameter int ENTRY_W = 64,
   parameter int DEPTH   = 64,
   parameter int IDX_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear_i,
   input  logic               wr_en_i,
   input  logic [IDX_W-1:0]   wr_idx_i,
   input  logic [ENTRY_W-1:0] wr_data_i,
   input  logic [IDX_W-1:0]   rd_idx_i,
   output logic [ENTRY_W-1:0] rd_data_o
);
   logic [ENTRY_W-1:0] mem [DEPTH];
   logic [DEPTH-1:0]   hit;

   for (genvar e = 0; e < DEPTH; e++) begin : g_dec
      assign hit[e] = wr_en_i && (wr_idx_i == IDX_W'(e));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
      end else if (clear_i) begin
         for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
      end else begin
         for (int e = 0; e < DEPTH; e++)
            if (hit[e]) mem[e] <= wr_data_i;
      end
   end

   assign rd_data_o = (32'(rd_idx_i) < DEPTH) ? mem[rd_idx_i] : '0;

   // R9
   entry_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i && !clear_i && (32'(wr_idx_i) < DEPTH) |=> mem[$past(wr_idx_i)] == $past(wr_data_i));
   // R7
   entry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (mem[0] == '0) && (mem[DEPTH-1] == '0));
endmodule

// File: rtl/iommu_page_calc.sv
module iommu_page_calc
   import iommu_xlate_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int ENTRY_W = 64,
   parameter int SHIFT_W = 5,
   parameter int CNT_W   = 7,
   parameter int IDX_W   = 6
) (
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               write_i,
   input  logic [SHIFT_W-1:0] shift_i,
   input  logic [ADDR_W-1:0]  offset_i,
   input  logic [CNT_W-1:0]   count_i,
   output logic [IDX_W-1:0]   idx_o,
   input  logic [ENTRY_W-1:0] entry_i,
   output logic [ENTRY_W-1:0] pa_o,
   output logic [ADDR_W-1:0]  iova_o,
   output logic [ENTRY_W-1:0] mask_o,
   output perm_e              perm_o,
   output logic               fault_o
);
   logic [ADDR_W-1:0]  rel, idx_full, pmask;
   logic [ENTRY_W-1:0] pmask_e;
   logic               below, oob;
   perm_e              code;

   assign below    = addr_i < offset_i;
   assign rel      = addr_i - offset_i;
   assign idx_full = rel >> shift_i;
   assign oob      = below || (idx_full >= ADDR_W'(count_i));
   assign pmask    = (ADDR_W'(1) << shift_i) - ADDR_W'(1);
   assign pmask_e  = ENTRY_W'(pmask);
   assign idx_o    = idx_full[IDX_W-1:0];
   assign code     = perm_e'(entry_i[1:0]);

   always_comb begin
      if (oob) begin
         pa_o    = '0;
         iova_o  = '0;
         mask_o  = '1;
         perm_o  = PERM_NONE;
         fault_o = 1'b1;
      end else begin
         pa_o    = (entry_i & ~pmask_e) | ENTRY_W'(rel & pmask);
         iova_o  = rel & ~pmask;
         mask_o  = pmask_e;
         perm_o  = code;
         fault_o = perm_blocks(code, write_i);
      end
   end
endmodule

// File: rtl/iommu_xlate_unit.sv
module iommu_xlate_unit
   import iommu_xlate_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int ENTRY_W   = 64,
   parameter int DEPTH     = 64,
   parameter int DEF_SHIFT = 12,
   localparam int IDX_W    = $clog2(DEPTH),
   localparam int CNT_W    = $clog2(DEPTH + 1),
   localparam int SHIFT_W  = $clog2(ADDR_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_enable,
   input  logic               cfg_disable,
   input  logic [SHIFT_W-1:0] cfg_shift,
   input  logic [ADDR_W-1:0]  cfg_offset,
   input  logic [ADDR_W-1:0]  cfg_count,
   input  logic               tbl_wr_en,
   input  logic [IDX_W-1:0]   tbl_wr_idx,
   input  logic [ENTRY_W-1:0] tbl_wr_data,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic               req_write,
   output logic               rsp_valid,
   input  logic               rsp_ready,
   output logic [ENTRY_W-1:0] rsp_pa,
   output logic [ADDR_W-1:0]  rsp_iova,
   output logic [ENTRY_W-1:0] rsp_mask,
   output logic [1:0]         rsp_perm,
   output logic               rsp_fault
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if ((1 << SHIFT_W) != ADDR_W) begin : g_bad_addr
      $error("ADDR_W must be a power of two");
   end
   if (ENTRY_W < ADDR_W) begin : g_bad_entry
      $error("ENTRY_W must not be narrower than ADDR_W");
   end
   if ((CNT_W >= ADDR_W) || (DEF_SHIFT >= ADDR_W)) begin : g_bad_fit
      $error("DEPTH or DEF_SHIFT too large for ADDR_W");
   end

   logic [SHIFT_W-1:0] win_shift;
   logic [ADDR_W-1:0]  win_offset;
   logic [CNT_W-1:0]   win_count;
   logic [IDX_W-1:0]   lk_idx;
   logic [ENTRY_W-1:0] lk_entry, lk_pa, lk_mask;
   logic [ADDR_W-1:0]  lk_iova;
   perm_e              lk_perm;
   logic               lk_fault, accept;

   iommu_win_cfg #(
      .ADDR_W(ADDR_W), .DEPTH(DEPTH), .SHIFT_W(SHIFT_W), .CNT_W(CNT_W), .DEF_SHIFT(DEF_SHIFT)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .en_i(cfg_enable), .dis_i(cfg_disable),
      .shift_i(cfg_shift), .offset_i(cfg_offset), .count_i(cfg_count),
      .shift_o(win_shift), .offset_o(win_offset), .count_o(win_count)
   );

   iommu_entry_table #(
      .ENTRY_W(ENTRY_W), .DEPTH(DEPTH), .IDX_W(IDX_W)
   ) u_tbl (
      .clk(clk), .rst_n(rst_n), .clear_i(cfg_disable),
      .wr_en_i(tbl_wr_en), .wr_idx_i(tbl_wr_idx), .wr_data_i(tbl_wr_data),
      .rd_idx_i(lk_idx), .rd_data_o(lk_entry)
   );

   iommu_page_calc #(
      .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W), .SHIFT_W(SHIFT_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
   ) u_calc (
      .addr_i(req_addr), .write_i(req_write), .shift_i(win_shift),
      .offset_i(win_offset), .count_i(win_count), .idx_o(lk_idx),
      .entry_i(lk_entry), .pa_o(lk_pa), .iova_o(lk_iova), .mask_o(lk_mask),
      .perm_o(lk_perm), .fault_o(lk_fault)
   );

   assign req_ready = !rsp_valid || rsp_ready;
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_pa    <= '0;
         rsp_iova  <= '0;
         rsp_mask  <= '0;
         rsp_perm  <= '0;
         rsp_fault <= 1'b0;
      end else if (accept) begin
         rsp_valid <= 1'b1;
         rsp_pa    <= lk_pa;
         rsp_iova  <= lk_iova;
         rsp_mask  <= lk_mask;
         rsp_perm  <= lk_perm;
         rsp_fault <= lk_fault;
      end else if (rsp_ready) begin
         rsp_valid <= 1'b0;
      end
   end

   // R8
   rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> rsp_valid);
   // R8
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_iova)
                                  && $stable(rsp_mask) && $stable(rsp_perm) && $stable(rsp_fault));
   // R3
   no_access_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && (rsp_perm == 2'd0) |-> rsp_fault);
   // R4
   oob_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && (rsp_mask == '1) |-> rsp_fault && (rsp_perm == 2'd0) && (rsp_pa == '0));
   // R5
   iova_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && (rsp_mask != '1) |-> ((rsp_iova & rsp_mask[ADDR_W-1:0]) == '0));
endmodule

// File: tb/iommu_xlate_unit_tb.sv
`timescale 1ns/1ps
module iommu_xlate_unit_tb;
   localparam int AW = 16;
   localparam int EW = 32;
   localparam int DP = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_enable = 0, cfg_disable = 0;
   logic [3:0]    cfg_shift = '0;
   logic [AW-1:0] cfg_offset = '0, cfg_count = '0;
   logic          tbl_wr_en = 0;
   logic [2:0]    tbl_wr_idx = '0;
   logic [EW-1:0] tbl_wr_data = '0;
   logic          req_valid = 0, req_write = 0, rsp_ready = 1;
   logic [AW-1:0] req_addr = '0;
   logic          req_ready, rsp_valid, rsp_fault;
   logic [EW-1:0] rsp_pa, rsp_mask;
   logic [AW-1:0] rsp_iova;
   logic [1:0]    rsp_perm;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   int            m_shift, m_count;
   logic [AW-1:0] m_off;
   logic [EW-1:0] m_tbl [DP];

   always #4 clk = ~clk;

   iommu_xlate_unit #(.ADDR_W(AW), .ENTRY_W(EW), .DEPTH(DP)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_disable(cfg_disable),
      .cfg_shift(cfg_shift), .cfg_offset(cfg_offset), .cfg_count(cfg_count),
      .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_data(tbl_wr_data),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_iova(rsp_iova),
      .rsp_mask(rsp_mask), .rsp_perm(rsp_perm), .rsp_fault(rsp_fault)
   );

   task automatic chk(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h (t=%0t)", tag, what, got, exp, $time);
      end
   endtask

   task automatic m_clear();
      m_shift = 0; m_off = '0; m_count = 0;
      for (int i = 0; i < DP; i++) m_tbl[i] = '0;
   endtask

   task automatic do_enable(input int sh, input logic [AW-1:0] off, input logic [AW-1:0] cnt);
      cfg_enable = 1; cfg_shift = 4'(sh); cfg_offset = off; cfg_count = cnt;
      @(negedge clk);
      cfg_enable = 0;
      if (m_count == 0) begin
         m_shift = sh; m_off = off; m_count = (cnt > DP) ? DP : int'(cnt);
      end
   endtask

   task automatic do_disable();
      cfg_disable = 1;
      @(negedge clk);
      cfg_disable = 0;
      m_clear();
   endtask

   task automatic do_write(input int idx, input logic [EW-1:0] d);
      tbl_wr_en = 1; tbl_wr_idx = 3'(idx); tbl_wr_data = d;
      @(negedge clk);
      tbl_wr_en = 0;
      m_tbl[idx] = d;
   endtask

   task automatic fill();
      for (int k = 0; k < DP; k++)
         do_write(k, (EW'(k + 1) << 12) | (EW'(k & 1) << 3) | EW'(k % 4));
   endtask

   task automatic expect_of(input logic [AW-1:0] a, input logic w,
                            output logic [EW-1:0] pa, output logic [AW-1:0] iova,
                            output logic [EW-1:0] mask, output logic [1:0] perm,
                            output logic fault, output logic oob);
      logic [AW-1:0] rel;
      logic [EW-1:0] pm, e;
      int idx;
      rel = a - m_off;
      idx = int'(rel) >> m_shift;
      oob = (a < m_off) || (idx >= m_count);
      if (oob) begin
         pa = '0; iova = '0; mask = '1; perm = 2'd0; fault = 1'b1;
      end else begin
         pm = (EW'(1) << m_shift) - 1;
         e = m_tbl[idx];
         pa = (e & ~pm) | (EW'(rel) & pm);
         iova = rel & ~AW'(pm);
         mask = pm;
         perm = e[1:0];
         fault = (perm == 2'd0) || (w ? (perm == 2'd1) : (perm == 2'd2));
      end
   endtask

   task automatic check_rsp(input logic [AW-1:0] a, input logic w);
      logic [EW-1:0] pa, mask;
      logic [AW-1:0] iova;
      logic [1:0] perm;
      logic fault, oob;
      expect_of(a, w, pa, iova, mask, perm, fault, oob);
      chk("R8", "rsp_valid", 64'(rsp_valid), 64'd1);
      chk(oob ? "R4" : "R5", "rsp_pa", 64'(rsp_pa), 64'(pa));
      chk(oob ? "R4" : "R5", "rsp_iova", 64'(rsp_iova), 64'(iova));
      chk(oob ? "R4" : "R5", "rsp_mask", 64'(rsp_mask), 64'(mask));
      chk(oob ? "R4" : "R2", "rsp_perm", 64'(rsp_perm), 64'(perm));
      chk(oob ? "R4" : "R3", "rsp_fault", 64'(rsp_fault), 64'(fault));
   endtask

   task automatic lookup(input logic [AW-1:0] a, input logic w);
      req_valid = 1; req_addr = a; req_write = w; rsp_ready = 1;
      @(negedge clk);
      req_valid = 0;
      check_rsp(a, w);
   endtask

   task automatic sweep(input int lo, input int hi, input int step);
      for (int a = lo; a <= hi; a += step) begin
         lookup(AW'(a), 1'b0);
         lookup(AW'(a), 1'b1);
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      m_clear();
      m_shift = 12;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: idle state after reset
      chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
      chk("R1", "req_ready", 64'(req_ready), 64'd1);
      lookup(16'h0000, 1'b0);   // R1: count 0 gives out-of-window fault
      lookup(16'h0123, 1'b1);

      // R1: entries are zero after reset, so every in-window page faults
      do_enable(2, 16'h0040, 16'd8);
      sweep(16'h40, 16'h5F, 4);

      // R9 R2 R3 R4 R5: full sweep around window, shift 2
      fill();
      sweep(16'h30, 16'h6F, 1);

      // R6: second enable while open is ignored
      do_enable(5, 16'h0000, 16'd2);
      sweep(16'h3C, 16'h64, 4);

      // R7: disable clears window and entries; reopen with shift 4, count 5
      do_disable();
      sweep(16'h40, 16'h44, 4);
      do_enable(4, 16'h0000, 16'd5);
      sweep(16'h00, 16'h4F, 16);
      fill();
      sweep(16'h00, 16'h8F, 3);

      // R6: count above depth saturates; shift 3, offset below window tested
      do_disable();
      do_enable(3, 16'h0100, 16'd20);
      fill();
      sweep(16'hF0, 16'h14F, 1);

      // R9: overwrite one entry and see it on the next lookup
      do_write(2, 32'h0000_ABC1);
      lookup(16'h0113, 1'b0);
      lookup(16'h0113, 1'b1);

      // R7: disable wins over enable and write in the same cycle
      cfg_disable = 1; cfg_enable = 1; cfg_shift = 4'd2; cfg_count = 16'd8; cfg_offset = 16'h0;
      tbl_wr_en = 1; tbl_wr_idx = 3'd0; tbl_wr_data = 32'h0000_5003;
      @(negedge clk);
      cfg_disable = 0; cfg_enable = 0; tbl_wr_en = 0;
      m_clear();
      lookup(16'h0000, 1'b0);
      do_enable(2, 16'h0000, 16'd8);
      lookup(16'h0001, 1'b0);   // entry 0 must still be zero

      // R8: backpressure holds the response and the next request
      do_write(1, 32'h0000_7003);
      rsp_ready = 0;
      req_valid = 1; req_addr = 16'h0005; req_write = 0;
      @(negedge clk);
      chk("R8", "req_ready stalled", 64'(req_ready), 64'd0);
      req_addr = 16'h0009; req_write = 1;
      repeat (2) @(negedge clk);
      check_rsp(16'h0005, 1'b0);
      rsp_ready = 1;
      @(negedge clk);
      req_valid = 0;
      check_rsp(16'h0009, 1'b1);
      @(negedge clk);
      chk("R8", "rsp_valid drained", 64'(rsp_valid), 64'd0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule